// File: doc/BRIEF.md
# Command Queue Instruction Executor

This block is a small sequencer that walks a program of 64-bit instructions held in an instruction memory. Software (or another engine) gives it a start address and an end address and pulses a start strobe. From then on the executor fetches one instruction per cycle from a combinational read port, drives register writes to a small set of addressed subsystems, optionally under a bit mask, and stalls on or updates single-bit hardware event flags. This lets a batch of register updates land in a tight time window, such as a display blanking interval.

Each instruction splits into an 8-bit opcode (bits [63:56]), a 24-bit argument A (bits [55:32]) and a 32-bit argument B (bits [31:0]). Five opcodes are decoded: 0x02 loads a write mask, 0x04 performs a register write, 0x10 jumps, 0x20 waits on and/or updates an event, and 0x40 marks the end of a command. The program counter is a byte address that steps by 8. Execution stops when it reaches the end address, or with an error pulse on anything the executor cannot decode.

Top module: `cq_sequencer`

## Requirements
- R1: After reset the executor is idle: `busy`, `wrValid`, `waiting`, `donePulse` and `errPulse` are 0, `evClr`/`evSet` are all zero and `imemAddr` is 0.
- R2: A `startPulse` while idle loads the program counter with `startAddr` and sets `busy` one cycle later. A `startPulse` while busy has no effect on the program counter.
- R3: Opcode 0x04 asserts `wrValid` for one cycle, with `wrData` equal to argument B and `wrAddr[15:0]` equal to argument A bits [15:0] with bit 0 forced to 0. The counter then advances by 8.
- R4: For opcode 0x04 with argument A bit 0 set, `wrMask` equals the bitwise inverse of argument B of the most recent 0x02 instruction (0 after reset). With bit 0 clear, `wrMask` is all ones. Opcode 0x02 produces no write and advances by 8.
- R5: Opcode 0x20 with argument B bit 15 set stalls while `evFlags[id]` differs from argument B bit 0. Here id is argument A bits [log2(NEV)-1:0]. During the stall `waiting` is 1 and the counter holds.
- R6: When an opcode 0x20 completes with argument B bit 31 set, it pulses the one-hot bit `id` on `evSet` if argument B bit 16 is 1, and on `evClr` otherwise. With argument B bit 15 clear it completes in one cycle without stalling.
- R7: Opcode 0x10 with argument A bit 0 = 0 adds argument B to the counter. With argument A bit 0 = 1 it loads argument B as the new counter.
- R8: While busy, the counter drives `imemAddr`. When it equals `endAddr` no instruction is executed and `busy` falls on the next cycle.
- R9: Opcode 0x40 pulses `donePulse` when argument B bit 0 is 1 and advances by 8 either way.
- R10: Any other opcode, or a 0x04 whose subsystem id is outside 1 to 3, pulses `errPulse` with no write, and the executor goes idle on the next cycle.
- R11: Subsystem ids 1, 2 and 3 (argument A bits [23:16]) give `wrAddr[31:16]` of 0x1400, 0x1401 and 0x1402.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Start execution when idle |
| startAddr | input | AW | First instruction byte address |
| endAddr | input | AW | Halt address |
| imemAddr | output | AW | Instruction fetch byte address |
| imemRdata | input | 64 | Instruction at `imemAddr` (same cycle) |
| wrValid | output | 1 | Register write strobe |
| wrAddr | output | 32 | Register write address |
| wrData | output | 32 | Register write data |
| wrMask | output | 32 | Bits to update (1 = write) |
| evFlags | input | NEV | Event flag levels |
| evClr | output | NEV | One-hot event clear pulse |
| evSet | output | NEV | One-hot event set pulse |
| waiting | output | 1 | Stalled on an event |
| busy | output | 1 | Executing a program |
| donePulse | output | 1 | End-of-command interrupt |
| errPulse | output | 1 | Decode error pulse |

## Verification
The bench builds the executor with a 32-bit counter and 16 event flags. The 16 flags keep the event id a 4-bit field, so wait and update pulses on several distinct flag positions are directly visible. A 64-entry program memory fits jump targets both ahead of and behind the current instruction, and leaves room for an end address that a jump lands on. Stalls are held for several cycles before the flag releases them, so the waiting status and the held counter are both observed.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam logic [7:0] OP_MASK  = 8'h02;
  localparam logic [7:0] OP_WRITE = 8'h04;
  localparam logic [7:0] OP_JUMP  = 8'h10;
  localparam logic [7:0] OP_EVENT = 8'h20;
  localparam logic [7:0] OP_EOC   = 8'h40;

  localparam logic [15:0] SUBSYS_HI_BASE = 16'h1400;
  localparam int unsigned SUBSYS_FIRST   = 1;
  localparam int unsigned SUBSYS_LAST    = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
    logic jumpRel;
    logic jumpAbs;
    logic loadMask;
  } cqStrobe_t;
endpackage

// File: rtl/cq_datapath.sv
module cq_datapath
  import cq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  cqStrobe_t     strb,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] endAddr,
  input  logic [23:0]   argA,
  input  logic [31:0]   argB,
  output logic [AW-1:0] pc,
  output logic          atEnd,
  output logic          subsysOk,
  output logic [31:0]   wrAddr,
  output logic [31:0]   wrData,
  output logic [31:0]   wrMask
);
  localparam logic [AW-1:0] STEP = AW'(8);

  logic [AW-1:0] pcQ;
  logic [31:0]   keepQ;
  logic [7:0]    subsys;
  logic [15:0]   hiHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (strb.loadStart) begin
      pcQ <= startAddr;
    end else if (strb.jumpAbs) begin
      pcQ <= argB[AW-1:0];
    end else if (strb.jumpRel) begin
      pcQ <= pcQ + argB[AW-1:0];
    end else if (strb.advance) begin
      pcQ <= pcQ + STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepQ <= '0;
    end else if (strb.loadMask) begin
      keepQ <= argB;
    end
  end

  always_comb begin
    subsys   = argA[23:16];
    subsysOk = (32'(subsys) >= SUBSYS_FIRST) && (32'(subsys) <= SUBSYS_LAST);
    hiHalf   = SUBSYS_HI_BASE + {8'h00, subsys} - 16'd1;
    wrAddr   = {hiHalf, argA[15:1], 1'b0};
    wrData   = argB;
    wrMask   = argA[0] ? ~keepQ : '1;
  end

  assign pc    = pcQ;
  assign atEnd = (pcQ == endAddr);
endmodule

// File: rtl/cq_control.sv
module cq_control
  import cq_pkg::*;
#(
  parameter int unsigned NEV = 16,
  localparam int unsigned EVW = (NEV > 1) ? $clog2(NEV) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startPulse,
  input  logic [7:0]     opcode,
  input  logic [EVW-1:0] evId,
  input  logic           modeBit,
  input  logic           updEn,
  input  logic           updVal,
  input  logic           waitEn,
  input  logic           lowBitB,
  input  logic           atEnd,
  input  logic           subsysOk,
  input  logic [NEV-1:0] evFlags,
  output cqStrobe_t      strb,
  output logic           busy,
  output logic           waiting,
  output logic           wrValid,
  output logic [NEV-1:0] evClr,
  output logic [NEV-1:0] evSet,
  output logic           donePulse,
  output logic           errPulse
);
  localparam logic [NEV-1:0] ONE = {{(NEV-1){1'b0}}, 1'b1};

  logic busyQ, busyD;
  logic clrFire, setFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= busyD;
  end

  always_comb begin
    strb      = '0;
    busyD     = busyQ;
    wrValid   = 1'b0;
    waiting   = 1'b0;
    clrFire   = 1'b0;
    setFire   = 1'b0;
    donePulse = 1'b0;
    errPulse  = 1'b0;
    if (!busyQ) begin
      if (startPulse) begin
        strb.loadStart = 1'b1;
        busyD          = 1'b1;
      end
    end else if (atEnd) begin
      busyD = 1'b0;
    end else begin
      case (opcode)
        OP_MASK: begin
          strb.loadMask = 1'b1;
          strb.advance  = 1'b1;
        end
        OP_WRITE: begin
          if (subsysOk) begin
            wrValid      = 1'b1;
            strb.advance = 1'b1;
          end else begin
            errPulse = 1'b1;
            busyD    = 1'b0;
          end
        end
        OP_JUMP: begin
          if (modeBit) strb.jumpAbs = 1'b1;
          else         strb.jumpRel = 1'b1;
        end
        OP_EVENT: begin
          if (waitEn && (evFlags[evId] != lowBitB)) begin
            waiting = 1'b1;
          end else begin
            strb.advance = 1'b1;
            if (updEn) begin
              if (updVal) setFire = 1'b1;
              else        clrFire = 1'b1;
            end
          end
        end
        OP_EOC: begin
          donePulse    = lowBitB;
          strb.advance = 1'b1;
        end
        default: begin
          errPulse = 1'b1;
          busyD    = 1'b0;
        end
      endcase
    end
  end

  assign evClr = clrFire ? (ONE << evId) : '0;
  assign evSet = setFire ? (ONE << evId) : '0;
  assign busy  = busyQ;
endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
  import cq_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned NEV = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startPulse,
  input  logic [AW-1:0]  startAddr,
  input  logic [AW-1:0]  endAddr,
  output logic [AW-1:0]  imemAddr,
  input  logic [63:0]    imemRdata,
  output logic           wrValid,
  output logic [31:0]    wrAddr,
  output logic [31:0]    wrData,
  output logic [31:0]    wrMask,
  input  logic [NEV-1:0] evFlags,
  output logic [NEV-1:0] evClr,
  output logic [NEV-1:0] evSet,
  output logic           waiting,
  output logic           busy,
  output logic           donePulse,
  output logic           errPulse
);
  localparam int unsigned EVW = (NEV > 1) ? $clog2(NEV) : 1;

  cqStrobe_t   strb;
  logic [7:0]  opcode;
  logic [23:0] argA;
  logic [31:0] argB;
  logic        atEnd;
  logic        subsysOk;

  assign opcode = imemRdata[63:56];
  assign argA   = imemRdata[55:32];
  assign argB   = imemRdata[31:0];

  cq_control #(.NEV(NEV)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .opcode    (opcode),
    .evId      (argA[EVW-1:0]),
    .modeBit   (argA[0]),
    .updEn     (argB[31]),
    .updVal    (argB[16]),
    .waitEn    (argB[15]),
    .lowBitB   (argB[0]),
    .atEnd     (atEnd),
    .subsysOk  (subsysOk),
    .evFlags   (evFlags),
    .strb      (strb),
    .busy      (busy),
    .waiting   (waiting),
    .wrValid   (wrValid),
    .evClr     (evClr),
    .evSet     (evSet),
    .donePulse (donePulse),
    .errPulse  (errPulse)
  );

  cq_datapath #(.AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startAddr(startAddr),
    .endAddr  (endAddr),
    .argA     (argA),
    .argB     (argB),
    .pc       (imemAddr),
    .atEnd    (atEnd),
    .subsysOk (subsysOk),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrMask   (wrMask)
  );
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int unsigned AW  = 32,
  parameter int unsigned NEV = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           startPulse,
  input logic [AW-1:0]  startAddr,
  input logic [AW-1:0]  imemAddr,
  input logic           wrValid,
  input logic [31:0]    wrAddr,
  input logic [NEV-1:0] evClr,
  input logic [NEV-1:0] evSet,
  input logic           waiting,
  input logic           busy,
  input logic           donePulse,
  input logic           errPulse
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!wrValid && !waiting && !donePulse && evClr == '0 && evSet == '0)); // R8

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> (busy && imemAddr == $past(startAddr))); // R2

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && waiting) |=> (busy && imemAddr == $past(imemAddr))); // R5

  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !busy); // R10

  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (!wrAddr[0] && wrAddr[31:16] >= 16'h1400 && wrAddr[31:16] <= 16'h1402)); // R11

  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (imemAddr == $past(imemAddr) + AW'(8))); // R9
endmodule

bind cq_sequencer cq_checker #(.AW(AW), .NEV(NEV)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .startAddr (startAddr),
  .imemAddr  (imemAddr),
  .wrValid   (wrValid),
  .wrAddr    (wrAddr),
  .evClr     (evClr),
  .evSet     (evSet),
  .waiting   (waiting),
  .busy      (busy),
  .donePulse (donePulse),
  .errPulse  (errPulse)
);

// File: tb/cq_sequencer_tb.sv
module cq_sequencer_tb;
  localparam int unsigned AW  = 32;
  localparam int unsigned NEV = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startPulse = 1'b0;
  logic [AW-1:0]  startAddr = '0;
  logic [AW-1:0]  endAddr = '0;
  logic [AW-1:0]  imemAddr;
  logic [63:0]    imemRdata;
  logic           wrValid;
  logic [31:0]    wrAddr, wrData, wrMask;
  logic [NEV-1:0] evFlags = '0;
  logic [NEV-1:0] evClr, evSet;
  logic           waiting, busy, donePulse, errPulse;

  logic [63:0] mem [0:63];
  int checks = 0;
  int failures = 0;

  // reference model state
  logic        mBusy = 1'b0;
  logic [31:0] mPc = '0;
  logic [31:0] mKeep = '0;

  always #2 clk = ~clk;

  assign imemRdata = mem[imemAddr[8:3]];

  cq_sequencer #(.AW(AW), .NEV(NEV)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .endAddr(endAddr), .imemAddr(imemAddr), .imemRdata(imemRdata),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask),
    .evFlags(evFlags), .evClr(evClr), .evSet(evSet), .waiting(waiting),
    .busy(busy), .donePulse(donePulse), .errPulse(errPulse)
  );

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [23:0] a,
                                     input logic [31:0] b);
    return {op, a, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [63:0] ins;
    logic [7:0]  op;
    logic [23:0] a;
    logic [31:0] b, eAddr, eData, eMask, nPc, nKeep;
    logic [NEV-1:0] eClr, eSet;
    logic eWv, eWait, eDone, eErr, nBusy;
    int sid, id;
    #1;
    ins = mem[mPc[8:3]];
    op = ins[63:56]; a = ins[55:32]; b = ins[31:0];
    eWv = 0; eWait = 0; eDone = 0; eErr = 0; eClr = '0; eSet = '0;
    eAddr = '0; eData = '0; eMask = '0;
    nBusy = mBusy; nPc = mPc; nKeep = mKeep;
    if (!mBusy) begin
      if (startPulse) begin nBusy = 1; nPc = startAddr; end
    end else if (mPc == endAddr) begin
      nBusy = 0;
    end else begin
      case (op)
        8'h02: begin nKeep = b; nPc = mPc + 8; end
        8'h04: begin
          sid = int'(a[23:16]);
          if (sid >= 1 && sid <= 3) begin
            eWv = 1;
            eAddr = {16'h1400 + 16'(sid - 1), a[15:1], 1'b0};
            eData = b;
            eMask = a[0] ? ~mKeep : 32'hFFFF_FFFF;
            nPc = mPc + 8;
          end else begin eErr = 1; nBusy = 0; end
        end
        8'h10: nPc = a[0] ? b : mPc + b;
        8'h20: begin
          id = int'(a[3:0]);
          if (b[15] && (evFlags[id] != b[0])) eWait = 1;
          else begin
            nPc = mPc + 8;
            if (b[31]) begin
              if (b[16]) eSet[id] = 1'b1;
              else       eClr[id] = 1'b1;
            end
          end
        end
        8'h40: begin eDone = b[0]; nPc = mPc + 8; end
        default: begin eErr = 1; nBusy = 0; end
      endcase
    end
    chk(imemAddr == mPc, "R2 R7 R8 imemAddr", imemAddr, mPc);
    chk(busy == mBusy, "R8 busy", 32'(busy), 32'(mBusy));
    chk(wrValid == eWv, "R3 wrValid", 32'(wrValid), 32'(eWv));
    if (eWv) begin
      chk(wrAddr == eAddr, "R3 R11 wrAddr", wrAddr, eAddr);
      chk(wrData == eData, "R3 wrData", wrData, eData);
      chk(wrMask == eMask, "R4 wrMask", wrMask, eMask);
    end
    chk(waiting == eWait, "R5 waiting", 32'(waiting), 32'(eWait));
    chk(evClr == eClr, "R6 evClr", 32'(evClr), 32'(eClr));
    chk(evSet == eSet, "R6 evSet", 32'(evSet), 32'(eSet));
    chk(donePulse == eDone, "R9 donePulse", 32'(donePulse), 32'(eDone));
    chk(errPulse == eErr, "R10 errPulse", 32'(errPulse), 32'(eErr));
    @(posedge clk);
    mBusy = nBusy; mPc = nPc; mKeep = nKeep;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] e);
    startAddr = s; endAddr = e; startPulse = 1'b1;
    tick();
    startPulse = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // program A: mask, plain and masked writes, clear-only event, EOC with irq
    mem[0]  = mk(8'h02, 24'h0, 32'hFFFF_0000);
    mem[1]  = mk(8'h04, {8'd1, 16'h0010}, 32'h1111_2222);
    mem[2]  = mk(8'h04, {8'd2, 16'h0021}, 32'hAAAA_5555);
    mem[3]  = mk(8'h20, 24'd3, 32'h8000_0000);
    mem[4]  = mk(8'h40, 24'h0, 32'h1);
    mem[5]  = mk(8'h10, 24'h0, 32'd8);
    // program B: wait-then-clear, write, absolute jump, set, wait-for-zero, new mask
    mem[8]  = mk(8'h20, 24'd5, 32'h8000_8001);
    mem[9]  = mk(8'h04, {8'd3, 16'h0104}, 32'hDEAD_BEEF);
    mem[10] = mk(8'h10, 24'd1, 32'd96);
    mem[11] = mk(8'h08, 24'h0, 32'h0);
    mem[12] = mk(8'h20, 24'd2, 32'h8001_0000);
    mem[13] = mk(8'h20, 24'd7, 32'h0000_8000);
    mem[14] = mk(8'h40, 24'h0, 32'h0);
    mem[15] = mk(8'h02, 24'h0, 32'h0000_FFFF);
    mem[16] = mk(8'h04, {8'd1, 16'h0031}, 32'h1234_5678);
    // program C: relative jump onto a write with a bad subsystem id
    mem[20] = mk(8'h10, 24'h0, 32'd16);
    mem[21] = mk(8'h40, 24'h0, 32'h1);
    mem[22] = mk(8'h04, {8'd7, 16'h0000}, 32'h0);
    // program D: unknown opcode
    mem[24] = mk(8'h01, 24'h0, 32'h0);
    // program F: forward, backward, then absolute jump to the end address
    mem[26] = mk(8'h10, 24'h0, 32'd16);
    mem[27] = mk(8'h10, 24'd1, 32'd240);
    mem[28] = mk(8'h10, 24'h0, 32'hFFFF_FFF8);

    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && wrValid == 0 && waiting == 0 && donePulse == 0 && errPulse == 0
        && evClr == '0 && evSet == '0 && imemAddr == '0,
        "R1 reset state", {busy, wrValid, waiting, donePulse, errPulse, imemAddr[26:0]}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 R4 R6 R9: program A, with an ignored second start (R2)
    launch(32'd0, 32'd48);
    run(2);
    startAddr = 32'd8; startPulse = 1'b1;
    tick();
    startPulse = 1'b0;
    run(7);

    // R5 R6 R7 R4: program B
    evFlags = '0; evFlags[7] = 1'b1;
    launch(32'd64, 32'd136);
    run(4);
    evFlags[5] = 1'b1;
    run(6);
    evFlags[7] = 1'b0;
    run(7);

    // R10: bad subsystem id after relative jump
    launch(32'd160, 32'd400);
    run(4);
    // R10: unknown opcode
    launch(32'd192, 32'd400);
    run(3);
    // R8: start equal to end
    launch(32'd32, 32'd32);
    run(3);
    // R7: backward relative and absolute jumps
    launch(32'd208, 32'd240);
    run(6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule